// File: doc/BRIEF.md
# I2C Master Byte Engine with Status Codes

This block is the master side of an I2C controller that advances by exactly one bus event per software command. Software sets bits in an 8-bit control register and loads an 8-bit data register. The engine then performs one event: a start, a repeated start, a byte out with acknowledge detection, a byte in with acknowledge generation, or a stop. When the event is over, the engine loads an 8-bit status code and raises a flag. The interrupt line follows that flag whenever the interrupt enable bit is set.

While the flag is up, the engine holds SCL low, so the bus waits for software. Software clears the flag by writing the control register with the flag bit at 0, and that write launches the next event. SCL and SDA are open-drain: each output, when high, pulls its line low, and each line is read back on its own input. Bit timing comes from an external sample tick. Each bit takes four ticks. The engine waits in the high phase until SCL is seen high. A synchronous soft reset returns the whole engine to its idle state.

Top module: `i2cs_master`

## Requirements
- R1: After `rst_n` or a one-cycle `soft_rst`, the control register reads 0x00, the status reads 0xF8, `irq` is 0 and both `scl_oe` and `sda_oe` are 0.
- R2: With enable set and the flag clear, writing START from idle produces a start condition, status 0x08 and a raised flag. A START issued while the engine still owns the bus (flag cleared from a hold) produces a repeated start and status 0x10.
- R3: The first byte after a start is an address. Its bit 0 is the direction (1 = read). It reports 0x18 or 0x20 (write, ACK or NACK) and 0x40 or 0x48 (read, ACK or NACK), and it goes out MSB first.
- R4: When an ACKed address byte has bits [7:3] = 11110, the next byte is the second byte of a ten-bit address. That byte reports 0xD0 or 0xD8 when the first byte's bit 0 was 0, and 0xE0 or 0xE8 when it was 1 (ACK or NACK).
- R5: In write mode, a data byte is sent MSB first and reports 0x28 if ACKed and 0x30 if NACKed.
- R6: In read mode, a received byte is answered with ACK (SDA low) and status 0x50 when control bit 2 is 1. It is answered with NACK and status 0x58 when bit 2 is 0. The byte is placed in the data register.
- R7: Clearing the flag with STOP (bit 4) set and enable set issues a stop condition, releases both lines, returns the status to 0xF8 and raises no flag.
- R8: While the flag (bit 3) is 1, SCL is held low and the status holds. Writing the control register with bit 3 = 1 leaves the flag set. Writing it with bit 3 = 0 clears the flag and starts the next event.
- R9: `irq` is 1 exactly when the flag is 1 and the interrupt enable (bit 7) is 1.
- R10: If SDA reads low during a transmitted 1 bit of an address or data byte, the engine releases both lines, reports 0x38 and raises the flag. The bus is then no longer owned, so the next START reports 0x08.
- R11: While enable (bit 6) is 0, a START request causes no bus activity and raises no flag.
- R12: The control register reads back interrupt enable at bit 7, enable at bit 6, START at bit 5, STOP at bit 4, flag at bit 3 and ACK at bit 2, with bits 1 and 0 reading 0. START and STOP clear themselves once their event is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset of the whole engine |
| tick | input | 1 | Bus phase tick; four ticks make one bit time |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 data |
| wr_data | input | 8 | Write value |
| ctrl_o | output | 8 | Control register readback |
| data_o | output | 8 | Data register (last received byte or loaded byte) |
| status_o | output | 8 | Status code of the last event |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
Two situations are the hardest to reach from the ports: losing arbitration and the second ten-bit address byte. Losing arbitration needs SDA pulled low by another party exactly while the engine sends a 1. The bench adds an override on the shared SDA wire and turns it on only while SCL is held low before an address byte whose MSB is 1. The second ten-bit address byte and its direction-dependent codes are only reachable after a start and an ACKed 11110xx header. The bench builds those sequences through a behavioural slave on the wired bus, which counts SCL edges, acknowledges or refuses on command, and serves read data.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_W = 8;

  // control register bit positions
  localparam int CB_ACK   = 2;
  localparam int CB_FLAG  = 3;
  localparam int CB_STOP  = 4;
  localparam int CB_START = 5;
  localparam int CB_EN    = 6;
  localparam int CB_IEN   = 7;

  localparam logic [7:0] ST_IDLE     = 8'hF8;
  localparam logic [7:0] ST_START    = 8'h08;
  localparam logic [7:0] ST_RSTART   = 8'h10;
  localparam logic [7:0] ST_WA_ACK   = 8'h18;
  localparam logic [7:0] ST_WA_NAK   = 8'h20;
  localparam logic [7:0] ST_WD_ACK   = 8'h28;
  localparam logic [7:0] ST_WD_NAK   = 8'h30;
  localparam logic [7:0] ST_ARB      = 8'h38;
  localparam logic [7:0] ST_RA_ACK   = 8'h40;
  localparam logic [7:0] ST_RA_NAK   = 8'h48;
  localparam logic [7:0] ST_RD_ACK   = 8'h50;
  localparam logic [7:0] ST_RD_NAK   = 8'h58;
  localparam logic [7:0] ST_W2_ACK   = 8'hD0;
  localparam logic [7:0] ST_W2_NAK   = 8'hD8;
  localparam logic [7:0] ST_R2_ACK   = 8'hE0;
  localparam logic [7:0] ST_R2_NAK   = 8'hE8;

  typedef enum logic [1:0] {OP_START, OP_STOP, OP_TX, OP_RX} phy_op_e;

  typedef enum logic [2:0] {
    EV_START, EV_ADDR, EV_ADDR2, EV_WDATA, EV_RDATA, EV_STOP
  } ev_kind_e;

  typedef enum logic [1:0] {CS_IDLE, CS_BUSY, CS_HOLD} ctl_state_e;

  function automatic logic is_ten_bit_head(input logic [7:0] b);
    return b[7:3] == 5'b11110;
  endfunction

  function automatic logic [7:0] event_code(input ev_kind_e k, input logic resent,
                                            input logic rd, input logic acked);
    case (k)
      EV_START: return resent ? ST_RSTART : ST_START;
      EV_ADDR:  return rd ? (acked ? ST_RA_ACK : ST_RA_NAK)
                          : (acked ? ST_WA_ACK : ST_WA_NAK);
      EV_ADDR2: return rd ? (acked ? ST_R2_ACK : ST_R2_NAK)
                          : (acked ? ST_W2_ACK : ST_W2_NAK);
      EV_WDATA: return acked ? ST_WD_ACK : ST_WD_NAK;
      EV_RDATA: return acked ? ST_RD_ACK : ST_RD_NAK;
      default:  return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/i2cs_bit_phy.sv
module i2cs_bit_phy
  import i2cs_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 abort,
  input  logic                 tick,
  input  logic                 go,
  input  phy_op_e              op,
  input  logic [BYTE_BITS-1:0] tx_byte,
  input  logic                 ack_drive,
  input  logic                 scl_in,
  input  logic                 sda_in,
  output logic                 done,
  output logic                 lost,
  output logic                 acked,
  output logic [BYTE_BITS-1:0] rx_byte,
  output logic                 scl_oe,
  output logic                 sda_oe
);

  localparam int BIT_W = $clog2(BYTE_BITS + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_BITS);

  logic                 run;
  phy_op_e              op_q;
  logic [1:0]           ph;
  logic [BIT_W-1:0]     bitn;
  logic [BYTE_BITS-1:0] sh, rx;
  logic                 ackv, scl_q, sda_q, done_q, lost_q, acked_q;

  logic is_data, tx_op, stall;
  assign is_data = (bitn != LAST_BIT);
  assign tx_op   = (op_q == OP_TX);
  assign stall   = (ph == 2'd2) && !scl_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; op_q <= OP_START; ph <= '0; bitn <= '0;
      sh <= '0; rx <= '0; ackv <= 1'b0;
      scl_q <= 1'b0; sda_q <= 1'b0;
      done_q <= 1'b0; lost_q <= 1'b0; acked_q <= 1'b0;
    end else if (abort) begin
      run <= 1'b0; scl_q <= 1'b0; sda_q <= 1'b0;
      done_q <= 1'b0; lost_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!run) begin
        if (go) begin
          run <= 1'b1; op_q <= op; ph <= '0; bitn <= '0;
          sh <= tx_byte; ackv <= ack_drive; lost_q <= 1'b0;
        end
      end else if (tick && !stall) begin
        ph <= ph + 2'd1;
        case (op_q)
          OP_START: begin
            case (ph)
              2'd0: sda_q <= 1'b0;
              2'd1: scl_q <= 1'b0;
              2'd2: sda_q <= 1'b1;
              default: begin scl_q <= 1'b1; run <= 1'b0; done_q <= 1'b1; end
            endcase
          end
          OP_STOP: begin
            case (ph)
              2'd0: sda_q <= 1'b1;
              2'd1: scl_q <= 1'b0;
              2'd2: sda_q <= 1'b0;
              default: begin run <= 1'b0; done_q <= 1'b1; end
            endcase
          end
          default: begin
            case (ph)
              2'd0: sda_q <= is_data ? (tx_op & ~sh[BYTE_BITS-1]) : (~tx_op & ackv);
              2'd1: scl_q <= 1'b0;
              2'd2: begin
                if (is_data) begin
                  if (tx_op && sh[BYTE_BITS-1] && !sda_in) begin
                    scl_q <= 1'b0; sda_q <= 1'b0; run <= 1'b0;
                    done_q <= 1'b1; lost_q <= 1'b1;
                  end else begin
                    rx <= {rx[BYTE_BITS-2:0], sda_in};
                    sh <= {sh[BYTE_BITS-2:0], 1'b0};
                  end
                end else begin
                  acked_q <= !sda_in;
                end
              end
              default: begin
                scl_q <= 1'b1;
                if (is_data) bitn <= bitn + BIT_W'(1);
                else begin run <= 1'b0; done_q <= 1'b1; end
              end
            endcase
          end
        endcase
      end
    end
  end

  assign done    = done_q;
  assign lost    = lost_q;
  assign acked   = acked_q;
  assign rx_byte = rx;
  assign scl_oe  = scl_q;
  assign sda_oe  = sda_q;

endmodule

// File: rtl/i2cs_event_ctl.sv
module i2cs_event_ctl
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [7:0]        ctrl_o,
  output logic [BYTE_W-1:0] data_o,
  output logic [7:0]        status_o,
  output logic              hold_o,
  output logic              phy_go,
  output phy_op_e           phy_op,
  output logic [BYTE_W-1:0] phy_tx,
  output logic              phy_ack,
  output logic              phy_abort,
  input  logic              phy_done,
  input  logic              phy_lost,
  input  logic              phy_acked,
  input  logic [BYTE_W-1:0] phy_rx
);

  ctl_state_e        state;
  ev_kind_e          kind, nxt;
  phy_op_e           op_q;
  logic              en, ien, sta, sto, ackb, flag;
  logic              resent, rd_mode, go_q, ack_q;
  logic [BYTE_W-1:0] data_q, tx_q;
  logic [7:0]        status_q;
  logic              rd_eff;

  assign rd_eff = (kind == EV_ADDR) ? tx_q[0] : rd_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CS_IDLE; kind <= EV_START; nxt <= EV_ADDR; op_q <= OP_START;
      en <= 1'b0; ien <= 1'b0; sta <= 1'b0; sto <= 1'b0; ackb <= 1'b0; flag <= 1'b0;
      resent <= 1'b0; rd_mode <= 1'b0; go_q <= 1'b0; ack_q <= 1'b0;
      data_q <= '0; tx_q <= '0; status_q <= ST_IDLE;
    end else if (soft_rst) begin
      state <= CS_IDLE; kind <= EV_START; nxt <= EV_ADDR; op_q <= OP_START;
      en <= 1'b0; ien <= 1'b0; sta <= 1'b0; sto <= 1'b0; ackb <= 1'b0; flag <= 1'b0;
      resent <= 1'b0; rd_mode <= 1'b0; go_q <= 1'b0; ack_q <= 1'b0;
      data_q <= '0; tx_q <= '0; status_q <= ST_IDLE;
    end else begin
      go_q <= 1'b0;
      case (state)
        CS_IDLE: begin
          if (en && sta && !flag) begin
            go_q <= 1'b1; op_q <= OP_START; kind <= EV_START;
            resent <= 1'b0; sta <= 1'b0; status_q <= ST_IDLE; state <= CS_BUSY;
          end else if (sto) begin
            sto <= 1'b0;
          end
        end
        CS_HOLD: begin
          if (!flag) begin
            go_q <= 1'b1; status_q <= ST_IDLE; state <= CS_BUSY;
            tx_q <= data_q; ack_q <= ackb;
            if (sta) begin
              op_q <= OP_START; kind <= EV_START; resent <= 1'b1; sta <= 1'b0;
            end else if (sto) begin
              op_q <= OP_STOP; kind <= EV_STOP; sto <= 1'b0;
            end else begin
              kind <= nxt;
              op_q <= (nxt == EV_RDATA) ? OP_RX : OP_TX;
            end
          end
        end
        default: begin
          if (phy_done) begin
            if (phy_lost) begin
              status_q <= ST_ARB; flag <= 1'b1; state <= CS_IDLE;
            end else if (kind == EV_STOP) begin
              status_q <= ST_IDLE; state <= CS_IDLE;
            end else begin
              status_q <= event_code(kind, resent, rd_eff, phy_acked);
              flag <= 1'b1; state <= CS_HOLD;
              case (kind)
                EV_START: nxt <= EV_ADDR;
                EV_ADDR: begin
                  rd_mode <= tx_q[0];
                  if (is_ten_bit_head(tx_q) && phy_acked) nxt <= EV_ADDR2;
                  else nxt <= tx_q[0] ? EV_RDATA : EV_WDATA;
                end
                EV_ADDR2: nxt <= rd_mode ? EV_RDATA : EV_WDATA;
                EV_RDATA: data_q <= phy_rx;
                default: ;
              endcase
            end
          end
        end
      endcase
      if (!en && state != CS_IDLE) begin
        state <= CS_IDLE; flag <= 1'b0; status_q <= ST_IDLE;
      end
      if (wr_en) begin
        if (!wr_sel) begin
          ien  <= wr_data[CB_IEN];
          en   <= wr_data[CB_EN];
          sta  <= wr_data[CB_START];
          sto  <= wr_data[CB_STOP];
          ackb <= wr_data[CB_ACK];
          if (!wr_data[CB_FLAG]) flag <= 1'b0;
        end else begin
          data_q <= wr_data;
        end
      end
    end
  end

  assign ctrl_o    = {ien, en, sta, sto, flag, ackb, 2'b00};
  assign data_o    = data_q;
  assign status_o  = status_q;
  assign hold_o    = (state == CS_HOLD);
  assign phy_go    = go_q;
  assign phy_op    = op_q;
  assign phy_tx    = tx_q;
  assign phy_ack   = ack_q;
  assign phy_abort = soft_rst | !en;

endmodule

// File: rtl/i2cs_master.sv
module i2cs_master
  import i2cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       tick,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] ctrl_o,
  output logic [7:0] data_o,
  output logic [7:0] status_o,
  output logic       irq,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);

  logic       hold_w, evt_go, evt_done, evt_lost, evt_acked, ack_w, abort_w;
  phy_op_e    op_w;
  logic [7:0] tx_w, rx_w;
  logic       flag_w, ien_w;

  i2cs_event_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_o(ctrl_o), .data_o(data_o), .status_o(status_o), .hold_o(hold_w),
    .phy_go(evt_go), .phy_op(op_w), .phy_tx(tx_w), .phy_ack(ack_w),
    .phy_abort(abort_w), .phy_done(evt_done), .phy_lost(evt_lost),
    .phy_acked(evt_acked), .phy_rx(rx_w)
  );

  i2cs_bit_phy #(.BYTE_BITS(BYTE_W)) u_phy (
    .clk(clk), .rst_n(rst_n), .abort(abort_w), .tick(tick),
    .go(evt_go), .op(op_w), .tx_byte(tx_w), .ack_drive(ack_w),
    .scl_in(scl_in), .sda_in(sda_in),
    .done(evt_done), .lost(evt_lost), .acked(evt_acked), .rx_byte(rx_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  assign flag_w = ctrl_o[CB_FLAG];
  assign ien_w  = ctrl_o[CB_IEN];
  assign irq    = flag_w & ien_w;

endmodule

// File: rtl/i2cs_master_chk.sv
module i2cs_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       hold,
  input logic       evt_done,
  input logic       evt_lost,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [7:0] status,
  input logic       flag,
  input logic       ien,
  input logic       irq
);

  // R8
  hold_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> scl_oe);

  // R10
  arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (evt_done && evt_lost) |=> (!scl_oe && !sda_oe && status == 8'h38 && flag));

  // R1
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status == 8'hF8 && !flag && !scl_oe && !sda_oe));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);

  // R2
  flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> status != 8'hF8);

endmodule

bind i2cs_master i2cs_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .hold(hold_w),
  .evt_done(evt_done), .evt_lost(evt_lost), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .status(status_o), .flag(flag_w), .ien(ien_w), .irq(irq)
);

// File: tb/i2cs_master_tb.sv
module i2cs_master_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;
  localparam logic [7:0] C_EN = 8'h40, C_IEN = 8'h80, C_STA = 8'h20,
                         C_STO = 8'h10, C_ACK = 8'h04, C_FLG = 8'h08;
  // {address byte, slave acks, expected status}
  localparam logic [16:0] ADDR_VEC [6] = '{
    {8'hA0, 1'b1, 8'h18}, {8'hA0, 1'b0, 8'h20},
    {8'hA1, 1'b1, 8'h40}, {8'hA1, 1'b0, 8'h48},
    {8'hF2, 1'b1, 8'h18}, {8'hF5, 1'b1, 8'h40}
  };

  logic clk = 0, rst_n = 0, soft_rst = 0, tick = 0;
  logic wr_en = 0, wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] ctrl_o, data_o, status_o;
  logic irq, scl_oe, sda_oe, scl_line, sda_line;

  logic s_drive = 0, force_low = 0, s_ack_en = 0, s_tx_mode = 0;
  logic [7:0] s_txb = 0, s_rx = 0;
  int   bitcnt = 0;
  logic p_scl = 1, p_sda = 1;
  int   tdiv = 0, cyc = 0, n_chk = 0, n_fail = 0;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe | s_drive | force_low);

  i2cs_master u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tick(tick),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_o(ctrl_o), .data_o(data_o), .status_o(status_o), .irq(irq),
    .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    tick <= (tdiv == 3);
  end

  // behavioural slave on the wired bus
  always @(posedge clk) begin
    p_scl <= scl_line;
    p_sda <= sda_line;
    if (scl_line && p_scl && (sda_line != p_sda)) bitcnt <= 0;
    else if (scl_line && !p_scl) begin
      if (bitcnt < 8) s_rx <= {s_rx[6:0], sda_line};
      if (bitcnt < 9) bitcnt <= bitcnt + 1;
    end else if (!scl_line && p_scl && bitcnt == 9) bitcnt <= 0;
    if (!scl_line)
      s_drive <= s_tx_mode ? (bitcnt < 8 && !s_txb[3'(7 - bitcnt)])
                           : (bitcnt == 8 && s_ack_en);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_ctrl(input logic [7:0] v);
    @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_data(input logic [7:0] v);
    @(negedge clk); wr_en = 1; wr_sel = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_flag();
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (ctrl_o[3]) break;
    end
  endtask

  task automatic send(input logic [7:0] b, input logic [7:0] c);
    do_data(b); do_ctrl(c); wait_flag();
  endtask

  task automatic stop_evt();
    do_ctrl(C_EN | C_IEN | C_STO);
    repeat (120) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", status_o, 8'hF8);
    check("R1 ctrl", ctrl_o, 8'h00);
    check("R1 lines", {6'd0, scl_oe, sda_oe}, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    // R11 start while disabled
    do_ctrl(C_IEN | C_STA);
    repeat (200) @(negedge clk);
    check("R11 ctrl", ctrl_o, 8'hA0);
    check("R11 status", status_o, 8'hF8);
    check("R11 scl", {7'd0, scl_oe}, 8'h00);
    do_ctrl(8'h00);

    // address table
    for (int i = 0; i < 6; i++) begin
      s_ack_en = ADDR_VEC[i][8];
      do_ctrl(C_EN | C_IEN | C_STA); wait_flag();
      check("R2 start", status_o, 8'h08);
      check("R12 ctrl", ctrl_o, 8'hC8);
      check("R9 irq", {7'd0, irq}, 8'h01);
      send(ADDR_VEC[i][16:9], C_EN | C_IEN);
      check("R3 status", status_o, ADDR_VEC[i][7:0]);
      check("R3 byte", s_rx, ADDR_VEC[i][16:9]);
      stop_evt();
      check("R7 status", status_o, 8'hF8);
      check("R7 ctrl", ctrl_o, 8'hC0);
      check("R7 lines", {6'd0, scl_oe, sda_oe}, 8'h00);
    end

    // R5 write data, R8 hold, R2 repeated start
    s_ack_en = 1;
    do_ctrl(C_EN | C_IEN | C_STA); wait_flag();
    send(8'h50, C_EN | C_IEN);
    check("R3 w ack", status_o, 8'h18);
    send(8'hC3, C_EN | C_IEN);
    check("R5 ack", status_o, 8'h28);
    check("R5 byte", s_rx, 8'hC3);
    s_ack_en = 0;
    send(8'h5A, C_EN | C_IEN);
    check("R5 nack", status_o, 8'h30);
    check("R5 byte2", s_rx, 8'h5A);
    do_ctrl(C_EN | C_IEN | C_FLG);
    repeat (80) @(negedge clk);
    check("R8 flag kept", {7'd0, ctrl_o[3]}, 8'h01);
    check("R8 scl held", {7'd0, scl_oe}, 8'h01);
    check("R8 status held", status_o, 8'h30);
    do_ctrl(C_EN | C_IEN | C_STA); wait_flag();
    check("R2 rstart", status_o, 8'h10);
    stop_evt();

    // R4 ten-bit write, ACK then NACK on second byte
    s_ack_en = 1;
    do_ctrl(C_EN | C_IEN | C_STA); wait_flag();
    send(8'hF0, C_EN | C_IEN);
    check("R4 head", status_o, 8'h18);
    send(8'h33, C_EN | C_IEN);
    check("R4 w2 ack", status_o, 8'hD0);
    stop_evt();
    do_ctrl(C_EN | C_IEN | C_STA); wait_flag();
    send(8'hF6, C_EN | C_IEN);
    s_ack_en = 0;
    send(8'h44, C_EN | C_IEN);
    check("R4 w2 nack", status_o, 8'hD8);
    stop_evt();

    // R4 ten-bit read then R6 receive
    s_ack_en = 1;
    do_ctrl(C_EN | C_IEN | C_STA); wait_flag();
    send(8'hF1, C_EN | C_IEN);
    check("R4 rhead", status_o, 8'h40);
    send(8'h12, C_EN | C_IEN);
    check("R4 r2 ack", status_o, 8'hE0);
    s_txb = 8'h96; s_tx_mode = 1;
    do_ctrl(C_EN | C_IEN | C_ACK); wait_flag();
    check("R6 ack", status_o, 8'h50);
    check("R6 data", data_o, 8'h96);
    s_txb = 8'h3C;
    do_ctrl(C_EN | C_IEN); wait_flag();
    check("R6 nack", status_o, 8'h58);
    check("R6 data2", data_o, 8'h3C);
    s_tx_mode = 0;
    stop_evt();

    // R9 flag without interrupt enable
    do_ctrl(C_EN | C_STA); wait_flag();
    check("R9 no irq", {7'd0, irq}, 8'h00);
    check("R9 flag", {7'd0, ctrl_o[3]}, 8'h01);
    stop_evt();

    // R10 arbitration loss
    do_ctrl(C_EN | C_IEN | C_STA); wait_flag();
    force_low = 1;
    send(8'hA0, C_EN | C_IEN);
    check("R10 status", status_o, 8'h38);
    check("R10 lines", {6'd0, scl_oe, sda_oe}, 8'h00);
    check("R10 irq", {7'd0, irq}, 8'h01);
    force_low = 0;
    repeat (10) @(negedge clk);
    do_ctrl(C_EN | C_IEN | C_STA); wait_flag();
    check("R10 fresh start", status_o, 8'h08);

    // R1 soft reset while holding
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    @(negedge clk);
    check("R1 srst status", status_o, 8'hF8);
    check("R1 srst ctrl", ctrl_o, 8'h00);
    check("R1 srst lines", {5'd0, irq, scl_oe, sda_oe}, 8'h00);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule